// File: doc/BRIEF.md
# Instruction Control Decoder

This block converts a 4-bit instruction operation code into the full set of control lines for a small 8-bit single-issue datapath. It drives the register-file write enable, data-memory write enable, destination register choice, ALU second-operand choice, write-back source, next-PC source, the link flag for call instructions, the register-jump flag and the ALU function. The map is fixed at sixteen codes. Register and immediate forms of an operation have separate codes, and one code does nothing at all.

Outputs are registered to suit an FPGA pipeline stage. Each output reflects the code sampled at the previous rising clock edge. A synchronous active-high reset forces every output to the same values as the idle code. The datapath that consumes these lines is outside this block.

Top module: `ctrl_decoder`

## Requirements
- R1: `reg_we` is 1 exactly for codes 0x0, 0x1, 0x2, 0x3, 0x4, 0x5, 0x6, 0x9, 0xB and 0xE, and 0 for all other codes.
- R2: `mem_we` is 1 only for the store code 0xC.
- R3: `wb_mem` (1 = memory data, 0 = ALU result) is 1 only for the load code 0xB.
- R4: `pc_src` is 3'b010 for 0x7 (branch if equal), 3'b011 for 0x8 (branch if not equal), 3'b100 for 0xA, 0xE and 0xF, and 3'b000 (next sequential) for every other code.
- R5: `b_imm` (1 = immediate operand) is 1 exactly for codes 0x2, 0x3, 0x6, 0xA, 0xB, 0xC and 0xE.
- R6: `link` is 1 only for code 0xE, and then `dst_sel` is 2'd2 (link register).
- R7: `reg_jump` is 1 only for code 0xF.
- R8: `dst_sel` is 2'd0 (Rd) for 0x0, 0x1, 0x4, 0x5 and 0x9, 2'd1 (Rt) for 0x2, 0x3, 0x6 and 0xB, and 2'd0 for codes that do not write a register.
- R9: `alu_fn` encodes and=0, or=1, add=2, sub=3, slt=4. Codes 0x0 and 0x2 give and, 0x1 and 0x3 give or, 0x4, 0x6, 0xA, 0xB, 0xC, 0xE and 0xF give add, 0x5, 0x7 and 0x8 give sub, and 0x9 gives slt.
- R10: Code 0xD drives every output to 0.
- R11: Outputs change one clock after the code is sampled. While `rst` is high at a rising edge, all outputs become 0 regardless of `opcode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Instruction operation code |
| reg_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Data memory write enable |
| dst_sel | output | 2 | Destination: 0 Rd, 1 Rt, 2 link register |
| b_imm | output | 1 | ALU operand B from immediate |
| wb_mem | output | 1 | Write-back from memory instead of ALU |
| pc_src | output | 3 | Next-PC source select |
| link | output | 1 | Call: save return address |
| reg_jump | output | 1 | Jump target taken from a register |
| alu_fn | output | 3 | ALU function code |

## Verification
On every cycle, the assertions check the cross-output rules. Memory write follows only a store code, and the two write enables never rise together. A link is always paired with a register write to the link register and a jump source. A register jump never coincides with a link, and memory write-back implies an immediate-operand register write. The PC selector never shows an unused value. The exact value each code produces for each field, the one-cycle latency and the reset override mid-stream can only be shown by the bench's table walk and its directed scenarios.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
  localparam int OPC_W    = 4;
  localparam int ALU_FN_W = 3;
  localparam int PC_SRC_W = 3;
  localparam int DST_W    = 2;

  typedef enum logic [OPC_W-1:0] {
    OP_AND  = 4'h0, OP_OR   = 4'h1, OP_ANDI = 4'h2, OP_ORI  = 4'h3,
    OP_ADD  = 4'h4, OP_SUB  = 4'h5, OP_ADDI = 4'h6, OP_BEQ  = 4'h7,
    OP_BNE  = 4'h8, OP_SLT  = 4'h9, OP_J    = 4'hA, OP_LW   = 4'hB,
    OP_SW   = 4'hC, OP_NOP  = 4'hD, OP_JAL  = 4'hE, OP_JR   = 4'hF
  } opcode_e;

  typedef enum logic [ALU_FN_W-1:0] {
    FN_AND = 3'd0, FN_OR = 3'd1, FN_ADD = 3'd2, FN_SUB = 3'd3, FN_SLT = 3'd4
  } alu_fn_e;

  typedef enum logic [PC_SRC_W-1:0] {
    PCS_SEQ = 3'b000, PCS_BEQ = 3'b010, PCS_BNE = 3'b011, PCS_JMP = 3'b100
  } pc_src_e;

  typedef enum logic [DST_W-1:0] {
    DST_RD = 2'd0, DST_RT = 2'd1, DST_LINK = 2'd2
  } dst_e;

  // instruction classes; the idle code sets none of them
  typedef struct packed {
    logic reg_alu;  // register-format ALU ops
    logic imm_alu;  // immediate-format ALU ops
    logic use_or;
    logic use_add;
    logic use_sub;
    logic use_slt;
    logic beq;
    logic bne;
    logic jabs;
    logic jal;
    logic jr;
    logic ld;
    logic st;
  } op_class_t;

  typedef struct packed {
    logic    reg_we;
    logic    mem_we;
    dst_e    dst;
    logic    b_imm;
    logic    wb_mem;
    pc_src_e pc_src;
    logic    link;
    logic    reg_jump;
    alu_fn_e alu_fn;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{reg_we: 1'b0, mem_we: 1'b0, dst: DST_RD,
                                  b_imm: 1'b0, wb_mem: 1'b0, pc_src: PCS_SEQ,
                                  link: 1'b0, reg_jump: 1'b0, alu_fn: FN_AND};
endpackage

// File: rtl/ctrl_opclass.sv
module ctrl_opclass
  import ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_class_t        cls
);
  always_comb begin
    cls = '0;
    unique case (opcode_e'(opcode))
      OP_AND:  cls.reg_alu = 1'b1;
      OP_OR:   begin cls.reg_alu = 1'b1; cls.use_or  = 1'b1; end
      OP_ANDI: cls.imm_alu = 1'b1;
      OP_ORI:  begin cls.imm_alu = 1'b1; cls.use_or  = 1'b1; end
      OP_ADD:  begin cls.reg_alu = 1'b1; cls.use_add = 1'b1; end
      OP_SUB:  begin cls.reg_alu = 1'b1; cls.use_sub = 1'b1; end
      OP_ADDI: begin cls.imm_alu = 1'b1; cls.use_add = 1'b1; end
      OP_BEQ:  cls.beq  = 1'b1;
      OP_BNE:  cls.bne  = 1'b1;
      OP_SLT:  begin cls.reg_alu = 1'b1; cls.use_slt = 1'b1; end
      OP_J:    cls.jabs = 1'b1;
      OP_LW:   cls.ld   = 1'b1;
      OP_SW:   cls.st   = 1'b1;
      OP_NOP:  cls = '0;
      OP_JAL:  cls.jal  = 1'b1;
      OP_JR:   cls.jr   = 1'b1;
      default: cls = '0;
    endcase
  end
endmodule

// File: rtl/ctrl_datapath_sel.sv
module ctrl_datapath_sel
  import ctrl_pkg::*;
(
  input  op_class_t cls,
  output logic      reg_we,
  output logic      mem_we,
  output dst_e      dst,
  output logic      b_imm,
  output logic      wb_mem,
  output alu_fn_e   alu_fn
);
  logic any_jump;
  logic mem_op;

  assign any_jump = cls.jabs | cls.jal | cls.jr;
  assign mem_op   = cls.ld | cls.st;

  assign reg_we = cls.reg_alu | cls.imm_alu | cls.ld | cls.jal;
  assign mem_we = cls.st;
  assign wb_mem = cls.ld;
  assign b_imm  = cls.imm_alu | mem_op | cls.jabs | cls.jal;

  always_comb begin
    if (cls.jal)                     dst = DST_LINK;
    else if (cls.imm_alu || cls.ld)  dst = DST_RT;
    else                             dst = DST_RD;
  end

  // branches subtract so the datapath can test the zero flag
  always_comb begin
    if (cls.use_slt)                               alu_fn = FN_SLT;
    else if (cls.use_sub || cls.beq || cls.bne)    alu_fn = FN_SUB;
    else if (cls.use_add || mem_op || any_jump)    alu_fn = FN_ADD;
    else if (cls.use_or)                           alu_fn = FN_OR;
    else                                           alu_fn = FN_AND;
  end
endmodule

// File: rtl/ctrl_flow_sel.sv
module ctrl_flow_sel
  import ctrl_pkg::*;
(
  input  logic    beq,
  input  logic    bne,
  input  logic    jabs,
  input  logic    jal,
  input  logic    jr,
  output pc_src_e pc_src,
  output logic    link,
  output logic    reg_jump
);
  always_comb begin
    if (jabs || jal || jr) pc_src = PCS_JMP;
    else if (bne)          pc_src = PCS_BNE;
    else if (beq)          pc_src = PCS_BEQ;
    else                   pc_src = PCS_SEQ;
  end

  assign link     = jal;
  assign reg_jump = jr;
endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [OPC_W-1:0]    opcode,
  output logic                reg_we,
  output logic                mem_we,
  output logic [DST_W-1:0]    dst_sel,
  output logic                b_imm,
  output logic                wb_mem,
  output logic [PC_SRC_W-1:0] pc_src,
  output logic                link,
  output logic                reg_jump,
  output logic [ALU_FN_W-1:0] alu_fn
);
  op_class_t cls;
  ctrl_t     nxt;
  ctrl_t     q;

  ctrl_opclass u_class (
    .opcode (opcode),
    .cls    (cls)
  );

  ctrl_datapath_sel u_dp (
    .cls    (cls),
    .reg_we (nxt.reg_we),
    .mem_we (nxt.mem_we),
    .dst    (nxt.dst),
    .b_imm  (nxt.b_imm),
    .wb_mem (nxt.wb_mem),
    .alu_fn (nxt.alu_fn)
  );

  ctrl_flow_sel u_flow (
    .beq      (cls.beq),
    .bne      (cls.bne),
    .jabs     (cls.jabs),
    .jal      (cls.jal),
    .jr       (cls.jr),
    .pc_src   (nxt.pc_src),
    .link     (nxt.link),
    .reg_jump (nxt.reg_jump)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= CTRL_IDLE;
    else     q <= nxt;
  end

  assign reg_we   = q.reg_we;
  assign mem_we   = q.mem_we;
  assign dst_sel  = q.dst;
  assign b_imm    = q.b_imm;
  assign wb_mem   = q.wb_mem;
  assign pc_src   = q.pc_src;
  assign link     = q.link;
  assign reg_jump = q.reg_jump;
  assign alu_fn   = q.alu_fn;

  AST_STORE_ONLY_WRITES_MEM: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(opcode) == OP_SW)); // R2
  AST_WRITES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && mem_we)); // R1
  AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    wb_mem |-> (reg_we && b_imm && ($past(opcode) == OP_LW))); // R3
  AST_LINK_PAIRING: assert property (@(posedge clk) disable iff (rst)
    link |-> (reg_we && dst_sel == DST_LINK && pc_src == PCS_JMP)); // R6
  AST_REGJUMP_SOLE: assert property (@(posedge clk) disable iff (rst)
    reg_jump |-> (pc_src == PCS_JMP && !link && !reg_we)); // R7
  AST_PCSRC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (pc_src == PCS_SEQ || pc_src == PCS_BEQ || pc_src == PCS_BNE || pc_src == PCS_JMP)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(opcode) == OP_NOP) |-> (!reg_we && !mem_we && pc_src == PCS_SEQ)); // R10
endmodule

// File: tb/ctrl_decoder_test.sv
`timescale 1ns/1ps
module ctrl_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opcode = 4'hD;
  logic       reg_we, mem_we, b_imm, wb_mem, link, reg_jump;
  logic [1:0] dst_sel;
  logic [2:0] pc_src, alu_fn;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ctrl_decoder uut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .reg_we(reg_we), .mem_we(mem_we), .dst_sel(dst_sel), .b_imm(b_imm),
    .wb_mem(wb_mem), .pc_src(pc_src), .link(link), .reg_jump(reg_jump),
    .alu_fn(alu_fn)
  );

  // {opcode, reg_we, mem_we, dst[1:0], b_imm, wb_mem, pc_src[2:0], link, reg_jump, alu_fn[2:0]}
  localparam logic [17:0] VEC [16] = '{
    18'b0000_1_0_00_0_0_000_0_0_000,
    18'b0001_1_0_00_0_0_000_0_0_001,
    18'b0010_1_0_01_1_0_000_0_0_000,
    18'b0011_1_0_01_1_0_000_0_0_001,
    18'b0100_1_0_00_0_0_000_0_0_010,
    18'b0101_1_0_00_0_0_000_0_0_011,
    18'b0110_1_0_01_1_0_000_0_0_010,
    18'b0111_0_0_00_0_0_010_0_0_011,
    18'b1000_0_0_00_0_0_011_0_0_011,
    18'b1001_1_0_00_0_0_000_0_0_100,
    18'b1010_0_0_00_1_0_100_0_0_010,
    18'b1011_1_0_01_1_1_000_0_0_010,
    18'b1100_0_1_00_1_0_000_0_0_010,
    18'b1101_0_0_00_0_0_000_0_0_000,
    18'b1110_1_0_10_1_0_100_1_0_010,
    18'b1111_0_0_00_0_0_100_0_1_010
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [13:0] e);
    chk("R1",  {tag, " reg_we"},   reg_we,   e[13]);
    chk("R2",  {tag, " mem_we"},   mem_we,   e[12]);
    chk("R8",  {tag, " dst_sel"},  dst_sel,  e[11:10]);
    chk("R5",  {tag, " b_imm"},    b_imm,    e[9]);
    chk("R3",  {tag, " wb_mem"},   wb_mem,   e[8]);
    chk("R4",  {tag, " pc_src"},   pc_src,   e[7:5]);
    chk("R6",  {tag, " link"},     link,     e[4]);
    chk("R7",  {tag, " reg_jump"}, reg_jump, e[3]);
    chk("R9",  {tag, " alu_fn"},   alu_fn,   e[2:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R11 reset state", 14'd0);
    rst = 1'b0;

    // table walk, one code per cycle
    for (int i = 0; i < 16; i++) begin
      opcode = VEC[i][17:14];
      @(negedge clk);
      chk_all($sformatf("code %0h", VEC[i][17:14]), VEC[i][13:0]);
      if (VEC[i][17:14] == 4'hD) chk("R10", "idle all zero", {reg_we, mem_we, dst_sel, b_imm, wb_mem, pc_src, link, reg_jump, alu_fn}, 0);
    end

    // R11 latency: new code not visible before the edge
    opcode = 4'hE;
    #1;
    chk("R11", "reg_we before edge", reg_we, 0);
    chk("R11", "reg_jump before edge", reg_jump, 1);
    @(negedge clk);
    chk_all("R11 after edge", VEC[14][13:0]);

    // R11 reset overrides an active call code
    rst = 1'b1;
    @(negedge clk);
    chk_all("R11 reset mid-stream", 14'd0);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R11 after release", VEC[14][13:0]);

    // alternating store/load stresses R2 and R3
    for (int k = 0; k < 4; k++) begin
      opcode = (k % 2 == 0) ? 4'hC : 4'hB;
      @(negedge clk);
      chk("R2", "alternate mem_we", mem_we, (k % 2 == 0) ? 1 : 0);
      chk("R3", "alternate wb_mem", wb_mem, (k % 2 == 0) ? 0 : 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule